// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block lets another bus master borrow the local bus through a level-sensitive request/acknowledge pair. The incoming request is asynchronous, so it first passes through a flop chain. The block then watches the phase of the bus cycle in progress, which the bus-cycle sequencer reports as inputs. It decides whether the bus may be handed over when that cycle ends. Once it hands the bus over, it raises the acknowledge and a float strobe half a clock later. The float strobe tristates the bus and control drivers. It also holds back any internal cycle that is waiting to start. When the synchronized request falls, the block takes the bus back.

Some conditions keep the bus from being lent: a locked sequence, the first pulse of an interrupt-acknowledge pair, the lower half of a word access split into two byte cycles, and a request that only becomes visible after the second phase of the cycle. A blocked request is not lost. It is honoured at the end of the next cycle that is free of these conditions, or on the first idle clock.

Top module: `bus_hold_arbiter`

## Requirements
- R1: `holdAsync` passes through `SYNC_STAGES` flops before it is used. With the bus idle and `lockIn` low, `hlda` is low after `SYNC_STAGES` rising edges following a rise of `holdAsync`, and it is high after the falling edge that follows rising edge `SYNC_STAGES`+1.
- R2: While `cycActive` is low, a synchronized request with `lockIn` low is granted on the next rising edge. `hlda` rises on the falling edge that follows that rising edge.
- R3: `busFloat` rises and falls on the same falling edge as `hlda`.
- R4: While the bus is lent, a synchronized request seen low returns the bus. `hlda` and `busFloat` fall on the falling edge after the rising edge at which the request is seen low.
- R5: `cycPhase` is encoded 0 = first phase, 1 = second phase, 2 = third phase or wait, 3 = final phase. During an active cycle, the bus is lent only at a rising edge with `cycPhase` = 3. This happens only if the synchronized request was high at a rising edge with `cycPhase` 0 or 1 in that same cycle.
- R6: A request first seen in phase 2 or 3 is not granted at the end of that cycle. It is granted at the end of the next cycle instead, including a cycle that follows back to back.
- R7: No grant is made at the end of a cycle that has `splitLow` high.
- R8: No grant is made at the end of a cycle that has `intaFirst` high.
- R9: No grant is made while `lockIn` is high, whether the bus is idle or in a cycle.
- R10: `cycStall` is high from the rising edge of the grant decision until `hlda` has fallen again.
- R11: While `rst_n` is low, `hlda`, `busFloat` and `cycStall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| holdAsync | input | 1 | Asynchronous bus request from the other master |
| cycActive | input | 1 | A bus cycle is in progress |
| cycPhase | input | 2 | Phase of the current cycle (0..3, 3 = final) |
| lockIn | input | 1 | Locked sequence in progress |
| intaFirst | input | 1 | Current cycle is the first interrupt-acknowledge pulse |
| splitLow | input | 1 | Current cycle is the lower half of a split word access |
| hlda | output | 1 | Bus acknowledge, changes on the falling edge |
| busFloat | output | 1 | Tristate strobe for bus and control drivers |
| cycStall | output | 1 | Holds back the start of internal cycles |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 rather than the default of two. A check that counts request-to-acknowledge latency exactly can therefore catch a chain that is one stage short, or a stage that is left out when the generate branch is chosen. The random phase runs the sequencer with variable wait phases, back-to-back cycles and randomly raised lock, split and acknowledge flags. This brings requests into reach that land in every phase, just before and just after the cutoff at the second phase.

// File: rtl/bha_pkg.sv
package bha_pkg;
  localparam int PHASE_W = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_FIRST  = 2'd0,
    PH_SECOND = 2'd1,
    PH_MID    = 2'd2,
    PH_LAST   = 2'd3
  } busPhase_e;

  typedef struct packed {
    logic armSet;
    logic armClr;
    logic floatReq;
  } ctlStrobes_t;
endpackage

// File: rtl/bha_control.sv
module bha_control
  import bha_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               holdSync,
  input  logic               armed,
  input  logic               cycActive,
  input  logic [PHASE_W-1:0] cycPhase,
  input  logic               lockIn,
  input  logic               intaFirst,
  input  logic               splitLow,
  output ctlStrobes_t        strb
);
  typedef enum logic {OWN_BUS, LENT_BUS} ownState_e;

  ownState_e state, nextState;
  logic      earlyPhase;
  logic      lastPhase;
  logic      idleGrant;
  logic      endGrant;

  assign earlyPhase = (cycPhase == PH_FIRST) || (cycPhase == PH_SECOND);
  assign lastPhase  = (cycPhase == PH_LAST);

  // Idle: the next clock may lend the bus. In a cycle: only its final phase.
  assign idleGrant = !cycActive && holdSync && !lockIn;
  assign endGrant  = cycActive && lastPhase && armed &&
                     !lockIn && !intaFirst && !splitLow;

  always_comb begin
    nextState = state;
    case (state)
      OWN_BUS:  if (idleGrant || endGrant) nextState = LENT_BUS;
      LENT_BUS: if (!holdSync) nextState = OWN_BUS;
      default:  nextState = OWN_BUS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= OWN_BUS;
    else        state <= nextState;
  end

  always_comb begin
    strb.armSet   = cycActive && earlyPhase && holdSync;
    strb.armClr   = !cycActive || lastPhase;
    strb.floatReq = (state == LENT_BUS);
  end
endmodule

// File: rtl/bha_datapath.sv
module bha_datapath
  import bha_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        holdAsync,
  input  ctlStrobes_t strb,
  output logic        holdSync,
  output logic        armed,
  output logic        hlda
);
  logic [SYNC_STAGES-1:0] syncQ;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ <= '0;
        else        syncQ <= holdAsync;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) syncQ <= '0;
        else        syncQ <= {syncQ[SYNC_STAGES-2:0], holdAsync};
      end
    end
  endgenerate

  assign holdSync = syncQ[SYNC_STAGES-1];

  // Remembers that the request was visible early enough in this cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           armed <= 1'b0;
    else if (strb.armClr) armed <= 1'b0;
    else if (strb.armSet) armed <= 1'b1;
  end

  // Acknowledge moves half a clock after the rising-edge decision.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) hlda <= 1'b0;
    else        hlda <= strb.floatReq;
  end
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import bha_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               holdAsync,
  input  logic               cycActive,
  input  logic [PHASE_W-1:0] cycPhase,
  input  logic               lockIn,
  input  logic               intaFirst,
  input  logic               splitLow,
  output logic               hlda,
  output logic               busFloat,
  output logic               cycStall
);
  ctlStrobes_t strb;
  logic        holdSync;
  logic        armed;
  logic        hldaQ;

  bha_control u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .holdSync  (holdSync),
    .armed     (armed),
    .cycActive (cycActive),
    .cycPhase  (cycPhase),
    .lockIn    (lockIn),
    .intaFirst (intaFirst),
    .splitLow  (splitLow),
    .strb      (strb)
  );

  bha_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .holdAsync (holdAsync),
    .strb      (strb),
    .holdSync  (holdSync),
    .armed     (armed),
    .hlda      (hldaQ)
  );

  assign hlda     = hldaQ;
  assign busFloat = hldaQ;
  assign cycStall = strb.floatReq | hldaQ;
endmodule

// File: rtl/bus_hold_arbiter_chk.sv
module bus_hold_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cycActive,
  input logic [1:0] cycPhase,
  input logic       lockIn,
  input logic       intaFirst,
  input logic       splitLow,
  input logic       hlda,
  input logic       busFloat,
  input logic       cycStall
);
  // R3: the tristate strobe is never active without the stall
  p_float_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busFloat |-> cycStall);

  // R10: acknowledge implies internal cycles are held back
  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> cycStall);

  // R5: a grant comes only from an idle clock or a final phase
  p_grant_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> $past(!cycActive || cycPhase == 2'd3));

  // R7
  p_no_split_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> !$past(cycActive && splitLow));

  // R8
  p_no_inta_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> !$past(cycActive && intaFirst));

  // R9
  p_no_lock_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> !$past(lockIn));
endmodule

bind bus_hold_arbiter bus_hold_arbiter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cycActive (cycActive),
  .cycPhase  (cycPhase),
  .lockIn    (lockIn),
  .intaFirst (intaFirst),
  .splitLow  (splitLow),
  .hlda      (hlda),
  .busFloat  (busFloat),
  .cycStall  (cycStall)
);

// File: tb/bus_hold_arbiter_bench.sv
module bus_hold_arbiter_bench;
  localparam int BENCH_SYNC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic holdAsync = 1'b0, cycActive = 1'b0, lockIn = 1'b0;
  logic intaFirst = 1'b0, splitLow = 1'b0;
  logic [1:0] cycPhase = 2'd0;
  logic hlda, busFloat, cycStall;

  always #5 clk = ~clk;

  bus_hold_arbiter #(.SYNC_STAGES(BENCH_SYNC)) u_bus_hold_arbiter (
    .clk(clk), .rst_n(rst_n), .holdAsync(holdAsync), .cycActive(cycActive),
    .cycPhase(cycPhase), .lockIn(lockIn), .intaFirst(intaFirst),
    .splitLow(splitLow), .hlda(hlda), .busFloat(busFloat), .cycStall(cycStall)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Reference model built from the requirements
  logic [BENCH_SYNC-1:0] mSync = '0;
  logic mArmed = 1'b0;
  logic mLent  = 1'b0;

  function automatic logic grantNow(logic hs, logic arm, logic act,
                                    logic [1:0] ph, logic lk, logic ia,
                                    logic sp);
    if (!act) return hs && !lk;
    return (ph == 2'd3) && arm && !lk && !ia && !sp;
  endfunction

  task automatic modelEdge();
    logic hs;
    hs = mSync[BENCH_SYNC-1];
    if (!mLent) mLent = grantNow(hs, mArmed, cycActive, cycPhase, lockIn,
                                 intaFirst, splitLow);
    else        mLent = hs;
    if (!cycActive || cycPhase == 2'd3) mArmed = 1'b0;
    else if (cycPhase <= 2'd1 && hs)    mArmed = 1'b1;
    mSync = {mSync[BENCH_SYNC-2:0], holdAsync};
  endtask

  task automatic cmp(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    cmp(tag, hlda, mLent);
    cmp("R3", busFloat, mLent);
    cmp("R10", cycStall, mLent);
  endtask

  task automatic step(string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    #2;
    checkAll(tag);
  endtask

  task automatic runCycle(string tag, int waits, logic lk, logic ia,
                          logic sp, int holdPhase);
    cycActive = 1'b1; lockIn = lk; intaFirst = ia; splitLow = sp;
    for (int p = 0; p < 4; p++) begin
      cycPhase = 2'(p);
      if (p == holdPhase) holdAsync = 1'b1;
      if (p == 2) for (int w = 0; w < waits; w++) step(tag);
      step(tag);
    end
  endtask

  task automatic releaseBus();
    cycActive = 1'b0; lockIn = 1'b0; intaFirst = 1'b0; splitLow = 1'b0;
    holdAsync = 1'b0;
    for (int i = 0; i < BENCH_SYNC + 1; i++) step("R4");
    cmp("R4", hlda, 1'b0);
  endtask

  task automatic idleLocked(int n);
    cycActive = 1'b0; lockIn = 1'b1; holdAsync = 1'b1;
    for (int i = 0; i < n; i++) step("R9");
    cmp("R9", hlda, 1'b0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nFails++;
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R11: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #2;
      cmp("R11", hlda, 1'b0); cmp("R11", busFloat, 1'b0); cmp("R11", cycStall, 1'b0);
    end
    holdAsync = 1'b1;
    @(negedge clk); #2;
    cmp("R11", hlda, 1'b0);
    holdAsync = 1'b0;
    rst_n = 1'b1;

    // R1 / R2: idle grant latency
    holdAsync = 1'b1;
    for (int i = 0; i < BENCH_SYNC; i++) step("R1");
    cmp("R1", hlda, 1'b0);
    step("R2");
    cmp("R2", hlda, 1'b1);
    cmp("R10", cycStall, 1'b1);
    // R4: release latency
    holdAsync = 1'b0;
    for (int i = 0; i < BENCH_SYNC; i++) step("R4");
    cmp("R4", hlda, 1'b1);
    step("R4");
    cmp("R4", hlda, 1'b0);

    // R5: request seen early, granted at end of cycle
    idleLocked(BENCH_SYNC + 3);
    runCycle("R5", 1, 1'b0, 1'b0, 1'b0, -1);
    cmp("R5", hlda, 1'b1);
    releaseBus();

    // R6: request seen late, waits for the next cycle
    runCycle("R6", 3, 1'b0, 1'b0, 1'b0, 1);
    cmp("R6", hlda, 1'b0);
    runCycle("R6", 0, 1'b0, 1'b0, 1'b0, -1);
    cmp("R6", hlda, 1'b1);
    releaseBus();

    // R7: split lower half blocks
    idleLocked(BENCH_SYNC + 3);
    runCycle("R7", 0, 1'b0, 1'b0, 1'b1, -1);
    cmp("R7", hlda, 1'b0);
    runCycle("R7", 0, 1'b0, 1'b0, 1'b0, -1);
    cmp("R7", hlda, 1'b1);
    releaseBus();

    // R8: first interrupt-acknowledge pulse blocks
    idleLocked(BENCH_SYNC + 3);
    runCycle("R8", 1, 1'b0, 1'b1, 1'b0, -1);
    cmp("R8", hlda, 1'b0);
    runCycle("R8", 1, 1'b0, 1'b0, 1'b0, -1);
    cmp("R8", hlda, 1'b1);
    releaseBus();

    // R9: lock blocks inside a cycle
    idleLocked(BENCH_SYNC + 3);
    runCycle("R9", 0, 1'b1, 1'b0, 1'b0, -1);
    cmp("R9", hlda, 1'b0);
    runCycle("R9", 0, 1'b0, 1'b0, 1'b0, -1);
    cmp("R9", hlda, 1'b1);
    releaseBus();

    // Random traffic checked against the model
    cycActive = 1'b0; lockIn = 1'b0; intaFirst = 1'b0; splitLow = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 10 == 0) holdAsync = ~holdAsync;
      if (!cycActive) begin
        if (!cycStall && $urandom % 3 == 0) begin
          cycActive = 1'b1; cycPhase = 2'd0;
          lockIn = ($urandom % 5 == 0); intaFirst = ($urandom % 6 == 0);
          splitLow = ($urandom % 5 == 0);
        end else begin
          lockIn = ($urandom % 4 == 0);
        end
      end else begin
        case (cycPhase)
          2'd0: cycPhase = 2'd1;
          2'd1: cycPhase = 2'd2;
          2'd2: cycPhase = ($urandom % 2 == 0) ? 2'd3 : 2'd2;
          default: begin
            if (!cycStall && $urandom % 2 == 0) begin
              cycPhase = 2'd0;
              lockIn = ($urandom % 5 == 0); intaFirst = ($urandom % 6 == 0);
              splitLow = ($urandom % 5 == 0);
            end else begin
              cycActive = 1'b0; intaFirst = 1'b0; splitLow = 1'b0;
            end
          end
        endcase
      end
      step("R2");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule